// File: doc/BRIEF.md
# Multi-Entry Unicast Address Filter

This block is the destination-address acceptance stage of a receive MAC. It holds ten 48-bit node addresses and a four-bit policy word. Both are loaded through a byte-wide paged register port. A received destination address is presented one byte per valid cycle, least significant byte first, after a one-cycle start strobe. All ten entries are compared in parallel, one byte at a time. The registered decision appears on the clock after the sixth byte.

The decision combines four things: the stored-entry match, a promiscuous mode, accept-all-multicast, and broadcast reject. For group addresses that are not broadcast, a one-bit hash-hit input from an external multicast hash lookup is also used. Class flags report whether the destination was a group address, whether it was the all-ones broadcast, and whether it matched an enabled entry. The start strobe snapshots the table and the policy word. Configuration writes made during a comparison therefore only affect the next frame.

Top module: `uaf_top`

## Requirements
- R1: Byte k of entry n (n = 0..9, k = 0..5) sits at linear offset L = 6n+k. Its register address is page 0x50 + L/8, register 8 + L%8, so an entry may span two pages. Byte 0 is compared with the first received destination byte.
- R2: A write outside the 60 table bytes changes no entry. This covers registers 0..7 of any page, registers 12..15 of page 0x57, and pages below 0x50 or above 0x57.
- R3: Entry 0 always takes part in matching. Entries 1..9 take part only when policy bit 1 (entry enable) is set. The policy word is at page 0x42, register 9, bits 3:0.
- R4: Policy bit 0 (promiscuous) accepts every destination with bit 0 of byte 0 clear. It does not accept group addresses.
- R5: A group destination (bit 0 of byte 0 set) that is not all-ones is accepted if it matches an enabled entry, or policy bit 3 (all multicast) is set, or hash_hit_i is high in the cycle of the sixth byte.
- R6: The all-ones destination is accepted unless policy bit 2 (broadcast reject) is set. It reports bcast_o=1 and mcast_o=1.
- R7: dec_valid_o is a one-cycle pulse in the cycle after the sixth byte is sampled. accept_o, match_o, mcast_o and bcast_o are valid with it and hold until the next decision. match_o is high when any enabled entry equals the destination.
- R8: The comparison uses the table and policy captured at da_start_i. A start strobe during a frame discards the partial frame and restarts. Valid bytes outside a frame are ignored.
- R9: After reset all outputs are 0, every table byte is 0x00 and the policy word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_page_i | input | 8 | Register page |
| cfg_reg_i | input | 4 | Register index within page |
| cfg_wdata_i | input | 8 | Write data |
| da_start_i | input | 1 | Start of a destination address |
| da_valid_i | input | 1 | Destination byte valid |
| da_byte_i | input | 8 | Destination byte |
| hash_hit_i | input | 1 | External hash lookup result, sampled with the sixth byte |
| dec_valid_o | output | 1 | Decision pulse |
| accept_o | output | 1 | Frame accepted |
| match_o | output | 1 | Matched an enabled stored entry |
| mcast_o | output | 1 | Group address |
| bcast_o | output | 1 | All-ones address |

## Verification
The hardest situation to reach is a configuration change that lands in the middle of a comparison. The stimulus sets up a matching frame and then, while its third and fourth bytes stream in, writes the policy word and one byte of the matched entry. It then checks that the decision still reflects the old values and that the next frame sees the new ones. Page-crossing entries are loaded with literal page and register numbers, not through computed offsets. Writes aimed just outside the table window are followed by frames that would expose any aliasing.

// File: rtl/uaf_pkg.sv
package uaf_pkg;
  typedef struct packed {
    logic all_mcast;  // bit 3
    logic bcast_rej;  // bit 2
    logic ia_en;      // bit 1
    logic promisc;    // bit 0
  } mode_t;
endpackage

// File: rtl/uaf_cfg_store.sv
module uaf_cfg_store #(
  parameter int         NUM_ENTRIES   = 10,
  parameter int         ADDR_BYTES    = 6,
  parameter int         REGS_PER_PAGE = 8,
  parameter int         REG_OFS       = 8,
  parameter logic [7:0] BASE_PAGE     = 8'h50,
  parameter logic [7:0] MODE_PAGE     = 8'h42,
  parameter logic [3:0] MODE_REG      = 4'h9,
  localparam int TOTAL_BYTES = NUM_ENTRIES * ADDR_BYTES,
  localparam int NUM_PAGES   = (TOTAL_BYTES + REGS_PER_PAGE - 1) / REGS_PER_PAGE
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [7:0]                 page_i,
  input  logic [3:0]                 reg_i,
  input  logic [7:0]                 wdata_i,
  input  logic                       snap_i,
  output logic [TOTAL_BYTES*8-1:0]   act_flat_o,
  output uaf_pkg::mode_t             act_mode_o
);
  logic [7:0] live_q [TOTAL_BYTES];
  logic [7:0] act_q  [TOTAL_BYTES];
  logic [TOTAL_BYTES*8-1:0] live_flat;
  uaf_pkg::mode_t live_mode_q, act_mode_q;

  logic        in_win, tab_we, mode_we;
  logic [15:0] lin;

  always_comb begin
    in_win = (16'(page_i) >= 16'(BASE_PAGE)) &&
             (16'(page_i) <  16'(BASE_PAGE) + 16'(NUM_PAGES)) &&
             (16'(reg_i)  >= 16'(REG_OFS)) &&
             (16'(reg_i)  <  16'(REG_OFS) + 16'(REGS_PER_PAGE));
    lin    = (16'(page_i) - 16'(BASE_PAGE)) * 16'(REGS_PER_PAGE)
           + 16'(reg_i) - 16'(REG_OFS);
    tab_we  = we_i && in_win && (lin < 16'(TOTAL_BYTES));
    mode_we = we_i && (page_i == MODE_PAGE) && (reg_i == MODE_REG);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TOTAL_BYTES; i++) begin
        live_q[i] <= '0;
        act_q[i]  <= '0;
      end
      live_mode_q <= '0;
      act_mode_q  <= '0;
    end else begin
      for (int i = 0; i < TOTAL_BYTES; i++)
        if (tab_we && lin == 16'(i)) live_q[i] <= wdata_i;
      if (mode_we) live_mode_q <= wdata_i[3:0];
      if (snap_i) begin
        act_q      <= live_q;
        act_mode_q <= live_mode_q;
      end
    end
  end

  for (genvar i = 0; i < TOTAL_BYTES; i++) begin : g_flat
    assign live_flat[i*8 +: 8]  = live_q[i];
    assign act_flat_o[i*8 +: 8] = act_q[i];
  end
  assign act_mode_o = act_mode_q;

  assert_win_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tab_we |=> $stable(live_flat));
  assert_snap_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> ($stable(act_flat_o) && $stable(act_mode_o)));
endmodule

// File: rtl/uaf_entry_cmp.sv
module uaf_entry_cmp #(
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W   = $clog2(ADDR_BYTES),
  localparam int ENTRY_W = ADDR_BYTES * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               en_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [7:0]         byte_i,
  input  logic [ENTRY_W-1:0] entry_i,
  output logic               mm_next_o
);
  logic       mm_q;
  logic [7:0] ref_b;

  always_comb begin
    ref_b = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (idx_i == IDX_W'(k)) ref_b = entry_i[8*k +: 8];
  end

  assign mm_next_o = mm_q | (en_i && (byte_i != ref_b));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mm_q <= 1'b0;
    else if (clear_i) mm_q <= 1'b0;
    else if (en_i)    mm_q <= mm_next_o;
  end

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !mm_q);
endmodule

// File: rtl/uaf_decide.sv
module uaf_decide #(
  parameter int NUM_ENTRIES = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   en_i,
  input  logic                   first_i,
  input  logic                   last_i,
  input  logic [7:0]             byte_i,
  input  logic [NUM_ENTRIES-1:0] hit_i,
  input  uaf_pkg::mode_t         mode_i,
  input  logic                   hash_hit_i,
  output logic                   dec_valid_o,
  output logic                   accept_o,
  output logic                   match_o,
  output logic                   mcast_o,
  output logic                   bcast_o
);
  logic ones_q, grp_q;
  logic ones_n, match_n, acc_n;

  always_comb begin
    ones_n  = ones_q && (byte_i == 8'hFF);
    match_n = |hit_i;
    if (ones_n)     acc_n = !mode_i.bcast_rej;
    else if (grp_q) acc_n = match_n | mode_i.all_mcast | hash_hit_i;
    else            acc_n = match_n | mode_i.promisc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= 1'b1;
      grp_q  <= 1'b0;
      dec_valid_o <= 1'b0;
      accept_o <= 1'b0;
      match_o  <= 1'b0;
      mcast_o  <= 1'b0;
      bcast_o  <= 1'b0;
    end else begin
      dec_valid_o <= en_i && last_i;
      if (clear_i) begin
        ones_q <= 1'b1;
        grp_q  <= 1'b0;
      end else if (en_i) begin
        ones_q <= ones_n;
        if (first_i) grp_q <= byte_i[0];
      end
      if (en_i && last_i) begin
        accept_o <= acc_n;
        match_o  <= match_n;
        mcast_o  <= grp_q;
        bcast_o  <= ones_n;
      end
    end
  end

  assert_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);
  assert_bcast_class_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && bcast_o) |-> mcast_o);
  assert_bcast_rej_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && bcast_o && mode_i.bcast_rej) |-> !accept_o);
  assert_promisc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !mcast_o && mode_i.promisc) |-> accept_o);
endmodule

// File: rtl/uaf_top.sv
module uaf_top #(
  parameter int NUM_ENTRIES = 10,
  parameter int ADDR_BYTES  = 6,
  localparam int IDX_W      = $clog2(ADDR_BYTES),
  localparam int ENTRY_W    = ADDR_BYTES * 8,
  localparam int TOTAL_BYTES = NUM_ENTRIES * ADDR_BYTES
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_page_i,
  input  logic [3:0] cfg_reg_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic       da_start_i,
  input  logic       da_valid_i,
  input  logic [7:0] da_byte_i,
  input  logic       hash_hit_i,
  output logic       dec_valid_o,
  output logic       accept_o,
  output logic       match_o,
  output logic       mcast_o,
  output logic       bcast_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  logic [TOTAL_BYTES*8-1:0] act_flat;
  uaf_pkg::mode_t           act_mode;
  logic                     in_frame_q, byte_en, is_first, is_last;
  logic [IDX_W-1:0]         idx_q;
  logic [NUM_ENTRIES-1:0]   mm_next, hit;

  assign byte_en  = da_valid_i && in_frame_q && !da_start_i;
  assign is_first = (idx_q == '0);
  assign is_last  = (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
    end else if (da_start_i) begin
      in_frame_q <= 1'b1;
      idx_q      <= '0;
    end else if (byte_en) begin
      idx_q <= idx_q + 1'b1;
      if (is_last) in_frame_q <= 1'b0;
    end
  end

  uaf_cfg_store #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_BYTES(ADDR_BYTES)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .page_i(cfg_page_i), .reg_i(cfg_reg_i), .wdata_i(cfg_wdata_i),
    .snap_i(da_start_i), .act_flat_o(act_flat), .act_mode_o(act_mode)
  );

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_ent
    uaf_entry_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
      .clk_i, .rst_ni,
      .clear_i(da_start_i), .en_i(byte_en), .idx_i(idx_q), .byte_i(da_byte_i),
      .entry_i(act_flat[n*ENTRY_W +: ENTRY_W]), .mm_next_o(mm_next[n])
    );
    if (n == 0) begin : g_always
      assign hit[n] = ~mm_next[n];
    end else begin : g_gated
      assign hit[n] = ~mm_next[n] & act_mode.ia_en;
    end
  end

  uaf_decide #(.NUM_ENTRIES(NUM_ENTRIES)) u_dec (
    .clk_i, .rst_ni,
    .clear_i(da_start_i), .en_i(byte_en), .first_i(is_first), .last_i(is_last),
    .byte_i(da_byte_i), .hit_i(hit), .mode_i(act_mode), .hash_hit_i,
    .dec_valid_o, .accept_o, .match_o, .mcast_o, .bcast_o
  );

  assert_frame_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> !in_frame_q);
  assert_no_gated_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_en && is_last && !act_mode.ia_en) |-> (hit[NUM_ENTRIES-1:1] == '0));
endmodule

// File: tb/uaf_top_tb_top.sv
module uaf_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_page = '0, cfg_wdata = '0;
  logic [3:0] cfg_reg = '0;
  logic da_start = 1'b0, da_valid = 1'b0, hash_hit = 1'b0;
  logic [7:0] da_byte = '0;
  logic dec_valid, accept, match, mcast, bcast;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  uaf_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_page_i(cfg_page), .cfg_reg_i(cfg_reg), .cfg_wdata_i(cfg_wdata),
    .da_start_i(da_start), .da_valid_i(da_valid), .da_byte_i(da_byte), .hash_hit_i(hash_hit),
    .dec_valid_o(dec_valid), .accept_o(accept), .match_o(match), .mcast_o(mcast), .bcast_o(bcast)
  );

  typedef struct packed {
    logic [47:0] da;
    logic [3:0]  mode;
    logic        hash;
    logic        acc;
    logic        mat;
    logic        mc;
    logic        bc;
  } vec_t;

  // mode: bit0 promisc, bit1 entry enable, bit2 bcast reject, bit3 all multicast
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{48'hA0_55_33_22_11_02, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R3 entry 0
    '{48'hA5_55_33_22_11_0C, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 entry 5 off
    '{48'hA5_55_33_22_11_0C, 4'b0010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R3
    '{48'hA9_55_33_22_11_14, 4'b0010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R1 R3
    '{48'hA1_55_33_22_11_04, 4'b0010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R1 literal pages
    '{48'hA1_55_33_22_11_02, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R1 mixed bytes
    '{48'h00_00_00_00_00_40, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R4
    '{48'h00_00_00_00_00_40, 4'b0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R4
    '{48'h01_00_5E_00_00_01, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R5
    '{48'h01_00_5E_00_00_01, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 hash
    '{48'h01_00_5E_00_00_01, 4'b1000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 all mcast
    '{48'h01_00_5E_00_00_01, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 promisc no mcast
    '{48'hFF_FF_FF_FF_FF_FF, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R6
    '{48'hFF_FF_FF_FF_FF_FF, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R6
    '{48'hFF_FF_FF_FF_FF_FF, 4'b1101, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R6 wins
    '{48'hFF_FF_FF_FF_FF_FE, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 near bcast
    '{48'h7F_FF_FF_FF_FF_FF, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}   // R5 near bcast
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] pg, logic [3:0] rg, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_page = pg; cfg_reg = rg; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_entry(int n, logic [47:0] a);
    for (int k = 0; k < 6; k++) begin
      int l = 6 * n + k;
      cfg_write(8'h50 + 8'(l / 8), 4'(8 + l % 8), a[8*k +: 8]);
    end
  endtask

  // returns at the negedge after the decision edge
  task automatic send_da(logic [47:0] a, logic h, bit mid);
    @(negedge clk);
    da_valid = 1'b0; da_start = 1'b1;
    @(negedge clk);
    da_start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      da_valid = 1'b1; da_byte = a[8*k +: 8];
      hash_hit = (k == 5) ? h : 1'b0;
      if (mid && k == 2) begin
        cfg_we = 1'b1; cfg_page = 8'h42; cfg_reg = 4'h9; cfg_wdata = 8'h00;
      end
      if (mid && k == 3) begin
        cfg_we = 1'b1; cfg_page = 8'h54; cfg_reg = 4'hB; cfg_wdata = 8'h00;
      end
      if (k == 4) cfg_we = 1'b0;
      @(negedge clk);
    end
    da_valid = 1'b0; hash_hit = 1'b0;
  endtask

  task automatic expect_dec(string req, logic acc, logic mat, logic mc, logic bc);
    check({req, " dec_valid"}, 32'(dec_valid), 32'd1);
    check({req, " accept"}, 32'(accept), 32'(acc));
    check({req, " match"}, 32'(match), 32'(mat));
    check({req, " mcast"}, 32'(mcast), 32'(mc));
    check({req, " bcast"}, 32'(bcast), 32'(bc));
    @(negedge clk);
    check({req, " pulse end R7"}, 32'(dec_valid), 32'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    @(negedge clk);
    check("R9 outputs", {27'd0, dec_valid, accept, match, mcast, bcast}, 32'd0);
    send_da(48'h0, 1'b0, 1'b0);
    expect_dec("R9 zero table", 1'b1, 1'b1, 1'b0, 1'b0);

    // load entries; entry 1 by literal page/register (R1)
    for (int n = 0; n < 10; n++)
      if (n != 1)
        write_entry(n, {8'hA0 + 8'(n), 8'h55, 8'h33, 8'h22, 8'h11, 8'h02 + 8'(2 * n)});
    cfg_write(8'h50, 4'hE, 8'h04);
    cfg_write(8'h50, 4'hF, 8'h11);
    cfg_write(8'h51, 4'h8, 8'h22);
    cfg_write(8'h51, 4'h9, 8'h33);
    cfg_write(8'h51, 4'hA, 8'h55);
    cfg_write(8'h51, 4'hB, 8'hA1);

    for (int i = 0; i < NV; i++) begin
      cfg_write(8'h42, 4'h9, {4'h0, VECS[i].mode});
      send_da(VECS[i].da, VECS[i].hash, 1'b0);
      expect_dec($sformatf("vec%0d R1/R3/R4/R5/R6", i),
                 VECS[i].acc, VECS[i].mat, VECS[i].mc, VECS[i].bc);
    end

    // R2 writes outside the table window
    cfg_write(8'h50, 4'h0, 8'hEE);
    cfg_write(8'h57, 4'hC, 8'hEE);
    cfg_write(8'h58, 4'h8, 8'hEE);
    cfg_write(8'h4F, 4'hF, 8'hEE);
    cfg_write(8'h42, 4'h9, 8'h02);
    send_da(48'hA0_55_33_22_11_02, 1'b0, 1'b0);
    expect_dec("R2 entry0 intact", 1'b1, 1'b1, 1'b0, 1'b0);
    send_da(48'hA9_55_33_22_11_14, 1'b0, 1'b0);
    expect_dec("R2 entry9 intact", 1'b1, 1'b1, 1'b0, 1'b0);

    // R8 writes mid-frame take effect on next frame only
    send_da(48'hA5_55_33_22_11_0C, 1'b0, 1'b1);
    expect_dec("R8 snapshot held", 1'b1, 1'b1, 1'b0, 1'b0);
    cfg_write(8'h42, 4'h9, 8'h02);
    send_da(48'hA5_55_33_22_11_0C, 1'b0, 1'b0);
    expect_dec("R8 new entry byte", 1'b0, 1'b0, 1'b0, 1'b0);
    send_da(48'h00_55_33_22_11_0C, 1'b0, 1'b0);
    expect_dec("R8 new entry match", 1'b1, 1'b1, 1'b0, 1'b0);

    // R8 restart mid-frame
    @(negedge clk);
    da_start = 1'b1;
    @(negedge clk);
    da_start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      da_valid = 1'b1; da_byte = 8'h99;
      @(negedge clk);
      check("R8 no early decision", 32'(dec_valid), 32'd0);
    end
    send_da(48'hA0_55_33_22_11_02, 1'b0, 1'b0);
    expect_dec("R8 restart", 1'b1, 1'b1, 1'b0, 1'b0);

    // R8 bytes outside a frame ignored
    begin
      int hits = 0;
      for (int k = 0; k < 8; k++) begin
        da_valid = 1'b1; da_byte = 8'hFF;
        @(negedge clk);
        if (dec_valid) hits++;
      end
      da_valid = 1'b0;
      check("R8 stray bytes", 32'(hits), 32'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule